// File: doc/BRIEF.md
# Sample-Time Register Busy Tracker for a Two-Channel Converter

This block sits between a fast bus clock domain and a slow low-speed clock domain. It belongs to a two-channel digital-to-analog converter. Each channel owns a sample-time configuration register that is physically held in the slow domain. A bus write to that register is captured in the fast domain and carried across with a toggle request / toggle acknowledge handshake. A per-channel busy flag stays high from the write until the slow domain has taken the value. While the flag is high, further writes to that channel are refused and flagged with a one-cycle reject pulse. Turning on a channel's hold mode also starts a transfer of the currently held value, so busy rises at mode enable as well.

The block also keeps one sticky DMA-underrun flag per channel. The flag is set when a conversion trigger arrives while the previous DMA request is still unserved. Software clears it by writing one to it. A registered copy of an external calibration comparator completes the flag set. All flags are packed into a 32-bit status word at fixed bit positions.

Top module: `dac_shb_tracker`

## Requirements
- R1: After reset the status word is 0, both slow-domain sample-time values are 0 and both reject pulses are low.
- R2: A write (`wr_valid`, channel `wr_sel`) to a channel whose busy flag is 0 is accepted: the busy flag reads 1 from the next fast cycle and the written value later appears on that channel's slow output.
- R3: A rising edge of `mode_en[c]` while channel c is idle sets its busy flag from the next fast cycle and re-sends the held value to the slow domain.
- R4: A write to a channel whose busy flag is 1 is dropped: the slow value is unaffected and `wr_reject[c]` is high for exactly the next fast cycle.
- R5: The busy flag goes back to 0 only after the slow output of that channel already holds the transferred value. It stays 1 while the old value is still shown.
- R6: The channels are independent: traffic, flags and clears on one channel never change the other channel's status bits or slow value.
- R7: The underrun flag of channel c is set when `conv_trig[c]` and `dma_pending[c]` are both 1 in a cycle, and it stays set afterwards.
- R8: A status write (`st_wr`) with `st_w1c[c]`=1 clears underrun flag c in the next cycle; with `st_w1c[c]`=0 the flag keeps its value.
- R9: If a set event and a write-one clear hit the same underrun flag in the same cycle, the flag ends up set.
- R10: The calibration status bit of channel c equals `cal_cmp[c]` delayed by one fast-clock edge.
- R11: Status bit positions are: channel 1 (index 0) busy 15, calibration 14, underrun 13. Channel 2 (index 1) uses busy 31, calibration 30, underrun 29. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast bus clock |
| rst_f | input | 1 | Synchronous active-high reset, fast domain |
| clk_s | input | 1 | Slow low-speed clock |
| rst_s | input | 1 | Synchronous active-high reset, slow domain |
| wr_valid | input | 1 | Sample-time register write strobe |
| wr_sel | input | 1 | Channel addressed by the write (0 or 1) |
| wr_data | input | 10 | Sample-time value to write |
| mode_en | input | 2 | Per-channel hold mode enable level |
| conv_trig | input | 2 | Per-channel conversion trigger pulse |
| dma_pending | input | 2 | Per-channel: previous DMA request still unserved |
| st_wr | input | 1 | Status write strobe |
| st_w1c | input | 2 | Underrun bits of the status write, 1 clears |
| cal_cmp | input | 2 | Calibration comparator outputs |
| status | output | 32 | Packed status word |
| wr_reject | output | 2 | One-cycle pulse per channel for a refused write |
| sh_time_s | output | 20 | Slow-domain sample-time values, channel c at bits [10c+9:10c] |

## Verification
The hardest situation to reach is a refused write: it needs a second write to land inside the few-cycle window in which the handshake is still open. It also needs the bench to prove that the refused value never reaches the slow domain. The stimulus issues the second write on the very next fast cycle after an accepted one. The scoreboard expects only the first value when busy falls. The slow clock period is not a multiple of the fast one, so the handshake latency varies between transfers. A monitor compares the slow output against the queue at each falling edge of busy, whatever the latency happens to be.

// File: rtl/dac_shb_pkg.sv
package dac_shb_pkg;

    localparam int NUM_CH    = 2;
    localparam int CH_STRIDE = 16;
    localparam int BUSY_OFS  = 15;
    localparam int CAL_OFS   = 14;
    localparam int UDR_OFS   = 13;

    typedef struct packed {
        logic busy;
        logic cal;
        logic udr;
    } ch_flags_t;

    function automatic int flag_pos(input int ch, input int ofs);
        return ch * CH_STRIDE + ofs;
    endfunction

    function automatic logic [31:0] used_mask();
        logic [31:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[flag_pos(c, BUSY_OFS)] = 1'b1;
            m[flag_pos(c, CAL_OFS)]  = 1'b1;
            m[flag_pos(c, UDR_OFS)]  = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] pack_status(input ch_flags_t [NUM_CH-1:0] f);
        logic [31:0] w;
        w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            w[flag_pos(c, BUSY_OFS)] = f[c].busy;
            w[flag_pos(c, CAL_OFS)]  = f[c].cal;
            w[flag_pos(c, UDR_OFS)]  = f[c].udr;
        end
        return w;
    endfunction

endpackage

// File: rtl/shb_xfer_chan.sv
module shb_xfer_chan #(
    parameter int VAL_W = 10
) (
    input  logic             clk_f,
    input  logic             rst_f,
    input  logic             clk_s,
    input  logic             rst_s,
    input  logic             wr_hit,
    input  logic [VAL_W-1:0] wr_data,
    input  logic             mode_en,
    output logic             busy,
    output logic             reject,
    output logic [VAL_W-1:0] slow_val
);

    // fast-domain state
    logic             req_t;
    logic             ack_f1, ack_f2;
    logic             mode_d;
    logic [VAL_W-1:0] hold_q;
    // slow-domain state
    logic             req_s1, req_s2;
    logic             ack_s;
    logic [VAL_W-1:0] slow_q;

    logic en_rise, accept, kick;

    always_comb begin
        busy    = req_t ^ ack_f2;
        en_rise = mode_en & ~mode_d;
        accept  = wr_hit & ~busy;
        kick    = accept | (en_rise & ~busy);
    end

    always_ff @(posedge clk_f) begin
        if (rst_f) begin
            req_t  <= 1'b0;
            ack_f1 <= 1'b0;
            ack_f2 <= 1'b0;
            mode_d <= 1'b0;
            hold_q <= '0;
            reject <= 1'b0;
        end else begin
            mode_d <= mode_en;
            ack_f1 <= ack_s;
            ack_f2 <= ack_f1;
            reject <= wr_hit & busy;
            if (accept) hold_q <= wr_data;
            if (kick)   req_t  <= ~req_t;
        end
    end

    // hold_q is stable whenever req_s2 differs from ack_s (busy is high)
    always_ff @(posedge clk_s) begin
        if (rst_s) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            ack_s  <= 1'b0;
            slow_q <= '0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            if (req_s2 != ack_s) begin
                slow_q <= hold_q;
                ack_s  <= req_s2;
            end
        end
    end

    assign slow_val = slow_q;

    assert_accept_busy_R2: assert property (@(posedge clk_f) disable iff (rst_f)
        accept |=> busy);
    assert_enable_busy_R3: assert property (@(posedge clk_f) disable iff (rst_f)
        (en_rise && !busy) |=> busy);
    assert_refuse_write_R4: assert property (@(posedge clk_f) disable iff (rst_f)
        (wr_hit && busy) |=> (reject && $stable(hold_q)));
    assert_hold_while_busy_R5: assert property (@(posedge clk_f) disable iff (rst_f)
        (busy && !wr_hit) |=> $stable(hold_q));
    assert_slow_idle_R5: assert property (@(posedge clk_s) disable iff (rst_s)
        (req_s2 == ack_s) |=> $stable(slow_q));

endmodule

// File: rtl/shb_udr_flag.sv
module shb_udr_flag (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic pending,
    input  logic clr_w1,
    output logic flag
);

    logic set_ev;

    always_comb set_ev = trig & pending;

    // set has priority over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= set_ev | (flag & ~clr_w1);
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_w1) |=> flag);
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_w1 && !set_ev) |=> !flag);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_ev) |=> !flag);

endmodule

// File: rtl/dac_shb_tracker.sv
module dac_shb_tracker
    import dac_shb_pkg::*;
#(
    parameter int VAL_W = 10
) (
    input  logic                    clk_f,
    input  logic                    rst_f,
    input  logic                    clk_s,
    input  logic                    rst_s,
    input  logic                    wr_valid,
    input  logic                    wr_sel,
    input  logic [VAL_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       mode_en,
    input  logic [NUM_CH-1:0]       conv_trig,
    input  logic [NUM_CH-1:0]       dma_pending,
    input  logic                    st_wr,
    input  logic [NUM_CH-1:0]       st_w1c,
    input  logic [NUM_CH-1:0]       cal_cmp,
    output logic [31:0]             status,
    output logic [NUM_CH-1:0]       wr_reject,
    output logic [NUM_CH*VAL_W-1:0] sh_time_s
);

    localparam logic [31:0] LIVE_BITS = used_mask();

    logic [NUM_CH-1:0] busy_w;
    logic [NUM_CH-1:0] udr_w;
    logic [NUM_CH-1:0] cal_q;
    ch_flags_t [NUM_CH-1:0] flags;

    always_ff @(posedge clk_f) begin
        if (rst_f) cal_q <= '0;
        else       cal_q <= cal_cmp;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_c;
        logic clr_c;
        always_comb begin
            hit_c = wr_valid && (wr_sel == c[0]);
            clr_c = st_wr && st_w1c[c];
        end

        shb_xfer_chan #(.VAL_W(VAL_W)) u_xfer (
            .clk_f    (clk_f),
            .rst_f    (rst_f),
            .clk_s    (clk_s),
            .rst_s    (rst_s),
            .wr_hit   (hit_c),
            .wr_data  (wr_data),
            .mode_en  (mode_en[c]),
            .busy     (busy_w[c]),
            .reject   (wr_reject[c]),
            .slow_val (sh_time_s[c*VAL_W +: VAL_W])
        );

        shb_udr_flag u_udr (
            .clk     (clk_f),
            .rst     (rst_f),
            .trig    (conv_trig[c]),
            .pending (dma_pending[c]),
            .clr_w1  (clr_c),
            .flag    (udr_w[c])
        );
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            flags[c].busy = busy_w[c];
            flags[c].cal  = cal_q[c];
            flags[c].udr  = udr_w[c];
        end
        status = pack_status(flags);
    end

    assert_spare_zero_R11: assert property (@(posedge clk_f) disable iff (rst_f)
        (status & ~LIVE_BITS) == 32'h0);
    assert_cal_delay_R10: assert property (@(posedge clk_f) disable iff (rst_f)
        status[CAL_OFS] == $past(cal_cmp[0]));

endmodule

// File: tb/tb_dac_shb_tracker.sv
`timescale 1ns/100ps
module tb_dac_shb_tracker;

    localparam int W = 10;

    logic          clk_f = 1'b0, clk_s = 1'b0;
    logic          rst_f, rst_s;
    logic          wr_valid, wr_sel;
    logic [W-1:0]  wr_data;
    logic [1:0]    mode_en, conv_trig, dma_pending, st_w1c, cal_cmp;
    logic          st_wr;
    logic [31:0]   status;
    logic [1:0]    wr_reject;
    logic [2*W-1:0] sh_time_s;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] exp_q0[$];
    logic [W-1:0] exp_q1[$];
    logic [W-1:0] last_v [2];
    logic prev_b0 = 1'b0, prev_b1 = 1'b0;

    always #2.5 clk_f = ~clk_f;   // 200 MHz
    always #18  clk_s = ~clk_s;   // slow clock, not a multiple of the fast one

    dac_shb_tracker #(.VAL_W(W)) dut (
        .clk_f(clk_f), .rst_f(rst_f), .clk_s(clk_s), .rst_s(rst_s),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_en(mode_en), .conv_trig(conv_trig), .dma_pending(dma_pending),
        .st_wr(st_wr), .st_w1c(st_w1c), .cal_cmp(cal_cmp),
        .status(status), .wr_reject(wr_reject), .sh_time_s(sh_time_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] slow_of(input int ch);
        return sh_time_s[ch*W +: W];
    endfunction

    // monitor: on each busy fall, pop the expected value and compare
    always @(negedge clk_f) begin
        if (rst_f) begin
            prev_b0 <= 1'b0;
            prev_b1 <= 1'b0;
        end else begin
            if (prev_b0 && !status[15]) begin
                if (exp_q0.size() == 0) chk("R5 ch0 unexpected transfer", 1, 0);
                else chk("R5 ch0 value at busy clear", 32'(slow_of(0)), 32'(exp_q0.pop_front()));
            end
            if (prev_b1 && !status[31]) begin
                if (exp_q1.size() == 0) chk("R5 ch1 unexpected transfer", 1, 0);
                else chk("R5 ch1 value at busy clear", 32'(slow_of(1)), 32'(exp_q1.pop_front()));
            end
            prev_b0 <= status[15];
            prev_b1 <= status[31];
        end
    end

    task automatic tick();
        @(negedge clk_f);
    endtask

    // driver: predicts acceptance from the busy bit seen before the edge
    task automatic do_write(input int ch, input logic [W-1:0] v);
        logic was_busy;
        was_busy = (ch == 0) ? status[15] : status[31];
        wr_valid = 1'b1; wr_sel = ch[0]; wr_data = v;
        if (!was_busy) begin
            last_v[ch] = v;
            if (ch == 0) exp_q0.push_back(v); else exp_q1.push_back(v);
        end
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle(input int ch);
        for (int i = 0; i < 300; i++) begin
            if (((ch == 0) ? status[15] : status[31]) == 1'b0) return;
            tick();
        end
        chk("R5 busy never cleared", 1, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_f = 1; rst_s = 1;
        wr_valid = 0; wr_sel = 0; wr_data = '0;
        mode_en = 0; conv_trig = 0; dma_pending = 0; st_wr = 0; st_w1c = 0; cal_cmp = 0;
        last_v[0] = '0; last_v[1] = '0;
        repeat (20) tick();
        rst_f = 0; rst_s = 0;
        tick();
        chk("R1 status after reset", status, 32'h0);
        chk("R1 slow values after reset", 32'(sh_time_s), 32'h0);
        chk("R1 reject after reset", 32'(wr_reject), 32'h0);

        // accepted write then immediate refused write on channel 0
        do_write(0, 10'h155);
        chk("R2 ch0 busy after write", 32'(status[15]), 1);
        chk("R5 old slow value while busy", 32'(slow_of(0)), 0);
        do_write(0, 10'h2AA);
        chk("R4 reject pulse", 32'(wr_reject), 32'h1);
        tick();
        chk("R4 reject lasts one cycle", 32'(wr_reject), 32'h0);
        wait_idle(0);
        tick();
        chk("R4 refused value absent", 32'(slow_of(0)), 32'h155);

        // channel 1 write, channel 0 untouched
        do_write(1, 10'h0F0);
        chk("R6 ch1 busy alone", status & 32'h8000_8000, 32'h8000_0000);
        chk("R6 ch0 slow unchanged", 32'(slow_of(0)), 32'h155);
        wait_idle(1);
        tick();
        chk("R2 ch1 value landed", 32'(slow_of(1)), 32'h0F0);

        // mode enable rising edge on channel 1
        mode_en[1] = 1'b1;
        exp_q1.push_back(last_v[1]);
        tick();
        chk("R3 busy on mode enable", 32'(status[31]), 1);
        chk("R3 ch0 not busy", 32'(status[15]), 0);
        wait_idle(1);
        tick();
        // held level does not retrigger
        repeat (3) tick();
        chk("R3 level does not retrigger", 32'(status[31]), 0);

        // back-to-back accepted writes on channel 0 after idle
        do_write(0, 10'h3FF);
        wait_idle(0);
        do_write(0, 10'h001);
        wait_idle(0);
        tick();
        chk("R2 ch0 second value", 32'(slow_of(0)), 32'h001);

        // underrun flags
        conv_trig = 2'b01; dma_pending = 2'b00; tick();
        conv_trig = 0;
        chk("R7 trigger without pending", 32'(status[13]), 0);
        conv_trig = 2'b01; dma_pending = 2'b01; tick();
        conv_trig = 0; dma_pending = 0;
        chk("R7 underrun set", status & 32'h2000_2000, 32'h0000_2000);
        repeat (2) tick();
        chk("R7 underrun sticky", 32'(status[13]), 1);
        st_wr = 1; st_w1c = 2'b00; tick(); st_wr = 0;
        chk("R8 write zero keeps flag", 32'(status[13]), 1);
        st_wr = 1; st_w1c = 2'b10; tick(); st_wr = 0; st_w1c = 0;
        chk("R6 clear of ch1 keeps ch0", 32'(status[13]), 1);
        st_wr = 1; st_w1c = 2'b01; tick(); st_wr = 0; st_w1c = 0;
        chk("R8 write one clears", 32'(status[13]), 0);
        conv_trig = 2'b10; dma_pending = 2'b10; st_wr = 1; st_w1c = 2'b10; tick();
        conv_trig = 0; dma_pending = 0; st_wr = 0; st_w1c = 0;
        chk("R9 set wins over clear", status & 32'h2000_2000, 32'h2000_0000);

        // calibration copy and bit layout
        cal_cmp = 2'b01; tick();
        chk("R10 cal ch0", status & 32'h4000_4000, 32'h0000_4000);
        cal_cmp = 2'b10; tick();
        chk("R10 cal ch1", status & 32'h4000_4000, 32'h4000_0000);
        cal_cmp = 2'b11;
        conv_trig = 2'b01; dma_pending = 2'b01; tick();
        conv_trig = 0; dma_pending = 0;
        do_write(0, 10'h0AA);
        chk("R11 status layout", status, 32'h6000_E000);
        wait_idle(0);
        repeat (4) tick();
        chk("R5 scoreboard drained", 32'(exp_q0.size() + exp_q1.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule